// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Modulator for a Five-Cell Cascaded Bridge Phase

This block drives the switch pairs of the five series-connected full-bridge cells that make up one phase of a cascaded multilevel converter. Each cell has its own triangular carrier, and the five carriers are spread evenly across one carrier period. A signed reference sample is first multiplied by a modulation gain and then scaled to the carrier amplitude. Every cell compares this scaled level against its own carrier. One leg of the cell follows the level, and the other leg follows the negated level. Each cell therefore contributes +V, 0 or -V, and the phase sum is an 11-level staircase. When a cell is bypassed, its gates are held low and the phase works with 9 levels. The gain can be raised to make up the lost voltage and can push the modulator into overmodulation.

The carrier period is set in units. With a setting of U, every carrier peaks at A = 5·U and repeats every 2·A clock cycles. Successive cells are offset by 2·U steps, which is one fifth of the period. A small sequencer keeps the carriers aligned. It has three states. SEQ_HOLD is entered on reset or whenever the setting is zero; all gates are low in this state. SEQ_ALIGN lasts one cycle, latches the setting and presets every carrier to its offset. SEQ_RUN is the modulating state. The transitions are:
- HOLD→ALIGN when the setting is nonzero.
- ALIGN→RUN when the setting is nonzero.
- ALIGN→HOLD when the setting is zero.
- RUN→ALIGN when the setting changes to another nonzero value.
- RUN→HOLD when the setting becomes zero.

Top module: `pscm_modulator`

## Requirements
- R1: While reset is asserted, and in SEQ_HOLD, every S1 and S2 output is 0. With a carrier setting of 0 the block stays in SEQ_HOLD.
- R2: From SEQ_HOLD, a nonzero setting moves the block to SEQ_ALIGN on the next clock and then to SEQ_RUN (back to SEQ_HOLD if the setting is 0 at that clock). Gates are low for the edge taken in SEQ_ALIGN.
- R3: The carrier of cell j (j = 0..4, bit j of every cell bus) is the triangle c(p) = p for p ≤ A and 2A-p otherwise. Here p = (k + 2·U·j) mod 2A, and k counts the clocks spent in SEQ_RUN since the last SEQ_ALIGN, starting at 0. The carrier used in the comparison is 2c-A.
- R4: The scaled reference is floor(ref·gain / 4096): the gain is unsigned with 12 fractional bits, so 4096 means 1.0. The result saturates to the signed 16-bit range instead of wrapping.
- R5: The level is L = floor(scaled·A / 16384). In SEQ_RUN, on each clock, S1[j] becomes (L > 2c-A) and S2[j] becomes (-L > 2c-A). The outputs are registered, one clock after the inputs.
- R6: A zero reference gives S1[j] = S2[j] for every cell, so each cell outputs zero.
- R7: When L exceeds A (overmodulation), every active cell holds S1 = 1 and S2 = 0 on every clock. When -L exceeds A, every active cell holds S1 = 0 and S2 = 1.
- R8: A cell whose bypass bit is 1 at a clock has S1 = S2 = 0 after that clock. The other cells keep their own carriers and slots.
- R9: In SEQ_RUN, a change of the setting to a different nonzero value restarts the carriers through one SEQ_ALIGN cycle, and the gates are low for that cycle.
- R10: In SEQ_RUN, a setting of 0 returns the block to SEQ_HOLD with all gates low.
- R11: The phase level, the count of S1 minus the count of S2, reaches ±5 with all cells active (11 levels). With one cell bypassed it is limited to ±4 (9 levels).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 16 | Signed reference sample |
| gain_i | input | 16 | Unsigned modulation gain, 12 fractional bits |
| cper_i | input | 8 | Carrier period setting U (period 10·U clocks, 0 = stop) |
| bypass_i | input | 5 | Per-cell bypass, bit j for cell j |
| s1_o | output | 5 | Leg following the level, bit j for cell j |
| s2_o | output | 5 | Leg following the negated level, bit j for cell j |

## Verification
The hardest situation to reach is a change of carrier setting in the middle of a period while a cell is bypassed and the gain holds the level near the carrier peak. The alignment restart, the unused carrier slot and the boundary between compare and overmodulation then interact. The stimulus gets there by first running long stretches of pseudo-random references at a fixed setting. It then forces saturation with large gains, bypasses one cell under full overmodulation, and finally switches the setting while running. A cycle-exact behavioural model tracks the triangle phase of every cell through each restart.

// File: rtl/pscm_pkg.sv
package pscm_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_ALIGN = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_t;

    typedef enum logic {
        CDIR_UP   = 1'b0,
        CDIR_DOWN = 1'b1
    } cdir_t;

endpackage

// File: rtl/pscm_ref_scale.sv
module pscm_ref_scale #(
    parameter int REF_W     = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int AMP_W     = 11,
    parameter int CMP_W     = 14
) (
    input  logic signed [REF_W-1:0]  ref_i,
    input  logic        [GAIN_W-1:0] gain_i,
    input  logic        [AMP_W-1:0]  amp_i,
    output logic signed [CMP_W-1:0]  lvl_o
);
    localparam int PW = REF_W + GAIN_W + 1;
    localparam int LW = REF_W + AMP_W + 1;
    localparam logic signed [PW-1:0] SAT_HI = PW'((2 ** (REF_W - 1)) - 1);
    localparam logic signed [PW-1:0] SAT_LO = ~SAT_HI;

    logic signed [PW-1:0]    ref_x;
    logic signed [PW-1:0]    gain_x;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    shr;
    logic signed [REF_W-1:0] sref;
    logic signed [LW-1:0]    sref_x;
    logic signed [LW-1:0]    amp_x;
    logic signed [LW-1:0]    prod2;

    // gain multiply, floor shift, saturate (no wrap)
    always_comb begin
        ref_x  = {{(PW-REF_W){ref_i[REF_W-1]}}, ref_i};
        gain_x = {{(PW-GAIN_W){1'b0}}, gain_i};
        prod   = ref_x * gain_x;
        shr    = prod >>> GAIN_FRAC;
        if (shr > SAT_HI) begin
            sref = REF_W'(SAT_HI);
        end else if (shr < SAT_LO) begin
            sref = REF_W'(SAT_LO);
        end else begin
            sref = REF_W'(shr);
        end
    end

    // map to carrier units: 2^(REF_W-2) equals the carrier peak
    always_comb begin
        sref_x = {{(LW-REF_W){sref[REF_W-1]}}, sref};
        amp_x  = {{(LW-AMP_W){1'b0}}, amp_i};
        prod2  = sref_x * amp_x;
        lvl_o  = CMP_W'(prod2 >>> (REF_W - 2));
    end

endmodule

// File: rtl/pscm_carrier.sv
module pscm_carrier
    import pscm_pkg::*;
#(
    parameter int PER_W    = 8,
    parameter int NCELL    = 5,
    parameter int CELL_IDX = 0,
    parameter int AMP_W    = 11,
    parameter int CMP_W    = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    run_i,
    input  logic [PER_W-1:0]        unit_ld_i,
    input  logic [AMP_W-1:0]        amp_i,
    output logic signed [CMP_W-1:0] car_o
);
    localparam int PH_W = AMP_W + 2;

    cdir_t             dir_q;
    logic [AMP_W-1:0]  cnt_q;
    logic [AMP_W-1:0]  amp_ld;
    logic [PH_W-1:0]   ofs_ld;
    logic [PH_W-1:0]   per_ld;
    logic              rising_ld;

    // preset point: offset of CELL_IDX fifths of the period
    always_comb begin
        amp_ld    = AMP_W'(unit_ld_i) * AMP_W'(NCELL);
        ofs_ld    = PH_W'(unit_ld_i) * PH_W'(2 * CELL_IDX);
        per_ld    = PH_W'(amp_ld) << 1;
        rising_ld = (ofs_ld <= PH_W'(amp_ld));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= CDIR_UP;
        end else if (load_i) begin
            if (rising_ld) begin
                cnt_q <= AMP_W'(ofs_ld);
                dir_q <= CDIR_UP;
            end else begin
                cnt_q <= AMP_W'(per_ld - ofs_ld);
                dir_q <= CDIR_DOWN;
            end
        end else if (run_i) begin
            unique case (dir_q)
                CDIR_UP: begin
                    if (cnt_q >= amp_i) begin
                        cnt_q <= cnt_q - 1'b1;
                        dir_q <= CDIR_DOWN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                CDIR_DOWN: begin
                    if (cnt_q == '0) begin
                        cnt_q <= cnt_q + 1'b1;
                        dir_q <= CDIR_UP;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    dir_q <= CDIR_UP;
                end
            endcase
        end
    end

    // bipolar carrier 2c - A
    always_comb begin
        car_o = $signed({2'b00, cnt_q, 1'b0}) - $signed({3'b000, amp_i});
    end

endmodule

// File: rtl/pscm_cell_gate.sv
module pscm_cell_gate #(
    parameter int CMP_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    byp_i,
    input  logic signed [CMP_W-1:0] lvl_i,
    input  logic signed [CMP_W-1:0] car_i,
    output logic                    s1_o,
    output logic                    s2_o
);
    logic               live;
    logic signed [CMP_W-1:0] nlvl;

    always_comb begin
        live = run_i && !byp_i;
        nlvl = -lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_o <= 1'b0;
            s2_o <= 1'b0;
        end else begin
            s1_o <= live && (lvl_i > car_i);
            s2_o <= live && (nlvl > car_i);
        end
    end

endmodule

// File: rtl/pscm_seq.sv
module pscm_seq
    import pscm_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cper_i,
    output seq_state_t       st_o,
    output logic [PER_W-1:0] unit_o,
    output logic             load_o,
    output logic             run_o
);
    seq_state_t       st_q;
    seq_state_t       st_d;
    logic [PER_W-1:0] unit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_HOLD:  if (cper_i != '0) st_d = SEQ_ALIGN;
            SEQ_ALIGN: st_d = (cper_i != '0) ? SEQ_RUN : SEQ_HOLD;
            SEQ_RUN: begin
                if (cper_i == '0) begin
                    st_d = SEQ_HOLD;
                end else if (cper_i != unit_q) begin
                    st_d = SEQ_ALIGN;
                end
            end
            default:   st_d = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q <= '0;
        end else if (st_q == SEQ_ALIGN) begin
            unit_q <= cper_i;
        end
    end

    always_comb begin
        st_o   = st_q;
        unit_o = unit_q;
        load_o = (st_q == SEQ_ALIGN);
        run_o  = (st_q == SEQ_RUN);
    end

endmodule

// File: rtl/pscm_modulator.sv
module pscm_modulator
    import pscm_pkg::*;
#(
    parameter int NCELL     = 5,
    parameter int REF_W     = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int PER_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [GAIN_W-1:0]       gain_i,
    input  logic [PER_W-1:0]        cper_i,
    input  logic [NCELL-1:0]        bypass_i,
    output logic [NCELL-1:0]        s1_o,
    output logic [NCELL-1:0]        s2_o
);
    localparam int AMP_W = PER_W + $clog2(NCELL);
    localparam int CMP_W = AMP_W + 3;

    seq_state_t              seq_st;
    logic [PER_W-1:0]        unit_q;
    logic                    seq_load;
    logic                    seq_run;
    logic [AMP_W-1:0]        amp_q;
    logic signed [CMP_W-1:0] lvl;
    logic signed [CMP_W-1:0] car_w [NCELL];
    logic signed [CMP_W-1:0] car0;

    pscm_seq #(.PER_W(PER_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cper_i (cper_i),
        .st_o   (seq_st),
        .unit_o (unit_q),
        .load_o (seq_load),
        .run_o  (seq_run)
    );

    always_comb begin
        amp_q = AMP_W'(unit_q) * AMP_W'(NCELL);
        car0  = car_w[0];
    end

    pscm_ref_scale #(
        .REF_W     (REF_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .AMP_W     (AMP_W),
        .CMP_W     (CMP_W)
    ) u_scale (
        .ref_i  (ref_i),
        .gain_i (gain_i),
        .amp_i  (amp_q),
        .lvl_o  (lvl)
    );

    for (genvar j = 0; j < NCELL; j++) begin : g_cell
        pscm_carrier #(
            .PER_W    (PER_W),
            .NCELL    (NCELL),
            .CELL_IDX (j),
            .AMP_W    (AMP_W),
            .CMP_W    (CMP_W)
        ) u_car (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (seq_load),
            .run_i     (seq_run),
            .unit_ld_i (cper_i),
            .amp_i     (amp_q),
            .car_o     (car_w[j])
        );

        pscm_cell_gate #(.CMP_W(CMP_W)) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (seq_run),
            .byp_i (bypass_i[j]),
            .lvl_i (lvl),
            .car_i (car_w[j]),
            .s1_o  (s1_o[j]),
            .s2_o  (s2_o[j])
        );
    end

endmodule

// File: rtl/pscm_chk.sv
module pscm_chk
    import pscm_pkg::*;
#(
    parameter int NCELL = 5,
    parameter int REF_W = 16,
    parameter int PER_W = 8,
    parameter int AMP_W = 11,
    parameter int CMP_W = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [REF_W-1:0] ref_i,
    input logic [PER_W-1:0]        cper_i,
    input logic [NCELL-1:0]        bypass_i,
    input logic [NCELL-1:0]        s1_o,
    input logic [NCELL-1:0]        s2_o,
    input seq_state_t              st,
    input logic [PER_W-1:0]        unit_q,
    input logic [AMP_W-1:0]        amp_q,
    input logic signed [CMP_W-1:0] car0
);
    logic signed [CMP_W-1:0] amp_s;
    always_comb amp_s = $signed({3'b000, amp_q});

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SEQ_RUN) |=> (s1_o == '0 && s2_o == '0)); // R1

    AST_ALIGN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_ALIGN && cper_i != '0) |=> (st == SEQ_RUN)); // R2

    AST_CAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_RUN) |-> (car0 <= amp_s && car0 >= -amp_s)); // R3

    AST_CAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_RUN) |=> (car0 == $past(car0) + 2 || car0 == $past(car0) - 2)); // R3

    AST_ZERO_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_i == '0) |=> (s1_o == s2_o)); // R6

    AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i != '0) |=> (((s1_o | s2_o) & $past(bypass_i)) == '0)); // R8

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_RUN && cper_i != '0 && cper_i != unit_q) |=> (st == SEQ_ALIGN)); // R9

    AST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_RUN && cper_i == '0) |=> (st == SEQ_HOLD)); // R10

endmodule

bind pscm_modulator pscm_chk #(
    .NCELL (NCELL),
    .REF_W (REF_W),
    .PER_W (PER_W),
    .AMP_W (AMP_W),
    .CMP_W (CMP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_i    (ref_i),
    .cper_i   (cper_i),
    .bypass_i (bypass_i),
    .s1_o     (s1_o),
    .s2_o     (s2_o),
    .st       (seq_st),
    .unit_q   (unit_q),
    .amp_q    (amp_q),
    .car0     (car0)
);

// File: tb/tb_pscm_modulator.sv
module tb_pscm_modulator;
    localparam int HALF = 2500; // 200 MHz at a 1 ps time unit

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [15:0] ref_i = '0;
    logic [15:0]       gain_i = '0;
    logic [7:0]        cper_i = '0;
    logic [4:0]        bypass_i = '0;
    logic [4:0]        s1_o;
    logic [4:0]        s2_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int  mst = 0;          // 0 hold, 1 align, 2 run
    int  mU = 0;
    int  mph = 0;
    logic [4:0] e1 = '0;
    logic [4:0] e2 = '0;
    int unsigned seed = 32'h1234_5678;

    always #HALF clk = ~clk;

    pscm_modulator dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_i    (ref_i),
        .gain_i   (gain_i),
        .cper_i   (cper_i),
        .bypass_i (bypass_i),
        .s1_o     (s1_o),
        .s2_o     (s2_o)
    );

    task automatic model_edge();
        longint sr;
        longint lv;
        int a;
        if (!rst_n) begin
            mst = 0; mU = 0; mph = 0; e1 = '0; e2 = '0;
            return;
        end
        e1 = '0; e2 = '0;
        if (mst == 2) begin
            a  = 5 * mU;
            sr = (longint'(ref_i) * longint'(gain_i)) >>> 12;
            if (sr > 32767) sr = 32767;
            if (sr < -32768) sr = -32768;
            lv = (sr * a) >>> 14;
            for (int j = 0; j < 5; j++) begin
                int p;
                int c;
                int cs;
                p  = (mph + 2 * mU * j) % (2 * a);
                c  = (p <= a) ? p : 2 * a - p;
                cs = 2 * c - a;
                e1[j] = !bypass_i[j] && (lv > cs);
                e2[j] = !bypass_i[j] && (-lv > cs);
            end
        end
        case (mst)
            0: if (cper_i != 0) mst = 1;
            1: begin
                mU = int'(cper_i); mph = 0;
                mst = (cper_i != 0) ? 2 : 0;
            end
            default: begin
                mph = (mph + 1) % (10 * mU);
                if (cper_i == 0) mst = 0;
                else if (int'(cper_i) != mU) mst = 1;
            end
        endcase
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({s1_o, s2_o} === {e1, e2}, cur_req, int'({s1_o, s2_o}), int'({e1, e2}));
    endtask

    function automatic int plevel();
        return $countones(s1_o) - $countones(s2_o);
    endfunction

    function automatic logic [15:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[27:12];
    endfunction

    initial begin
        repeat (3) tick();
        chk(s1_o == 0 && s2_o == 0, "R1", int'({s1_o, s2_o}), 0);
        rst_n = 1'b1;
        repeat (5) tick();
        chk(s1_o == 0 && s2_o == 0, "R1", int'({s1_o, s2_o}), 0);

        // start carriers
        cur_req = "R2"; cper_i = 8'd3; gain_i = 16'd4096; ref_i = 16'sd8192;
        tick(); tick();
        chk(s1_o == 0 && s2_o == 0, "R2", int'({s1_o, s2_o}), 0);
        cur_req = "R3";
        repeat (60) tick();
        cur_req = "R5";
        for (int i = 0; i < 200; i++) begin
            ref_i = $signed(rnd()); gain_i = 16'd2048 + {4'd0, rnd()[11:0]};
            tick();
        end
        cur_req = "R4";
        for (int i = 0; i < 120; i++) begin
            ref_i = $signed(rnd()); gain_i = 16'hFFFF - {8'd0, rnd()[7:0]};
            tick();
        end
        cur_req = "R6"; ref_i = '0; gain_i = 16'd12000;
        for (int i = 0; i < 40; i++) begin
            tick();
            chk(s1_o == s2_o, "R6", int'(s1_o), int'(s2_o));
        end
        cur_req = "R7"; ref_i = 16'sd32767; gain_i = 16'd4096;
        tick();
        for (int i = 0; i < 35; i++) begin
            tick();
            chk(s1_o == 5'h1F && s2_o == 0, "R7", int'({s1_o, s2_o}), 10'h3E0);
            chk(plevel() == 5, "R11", plevel(), 5);
        end
        ref_i = -16'sd32768;
        tick();
        for (int i = 0; i < 35; i++) begin
            tick();
            chk(plevel() == -5, "R7", plevel(), -5);
        end
        cur_req = "R8"; bypass_i = 5'b00100;
        tick();
        for (int i = 0; i < 30; i++) begin
            tick();
            chk(plevel() == -4, "R11", plevel(), -4);
            chk(((s1_o | s2_o) & 5'b00100) == 0, "R8", int'(s1_o | s2_o), 0);
        end
        for (int i = 0; i < 100; i++) begin
            ref_i = $signed(rnd()); gain_i = 16'd3000 + {4'd0, rnd()[11:0]};
            tick();
            chk(((s1_o | s2_o) & 5'b00100) == 0, "R8", int'(s1_o | s2_o), 0);
        end
        cur_req = "R9"; ref_i = 16'sd9000; gain_i = 16'd5000; cper_i = 8'd5;
        tick(); tick();
        chk(s1_o == 0 && s2_o == 0, "R9", int'({s1_o, s2_o}), 0);
        for (int i = 0; i < 110; i++) begin
            ref_i = $signed(rnd());
            tick();
        end
        bypass_i = '0;
        repeat (20) tick();
        cur_req = "R10"; cper_i = '0;
        tick(); tick();
        for (int i = 0; i < 10; i++) begin
            tick();
            chk(s1_o == 0 && s2_o == 0, "R10", int'({s1_o, s2_o}), 0);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule